// File: doc/BRIEF.md
# Two-Level Indirect Branch Target Cache

This block predicts the targets of indirect branches for a fetch unit, keyed by the fetch PC. A small fully associative level-0 table answers in the same cycle as the lookup, so a hit there costs the fetch stream no bubble. Behind it sits a larger set-associative level-1 table. When level-0 misses and level-1 hits, the level-1 table reports its answer on a separate registered output one cycle after the lookup.

A resolved indirect branch arrives on the update port. It trains both tables with the correct target, either correcting an existing entry in place or allocating a new one. A level-1 hit that missed level-0 promotes the entry into level-0, so a repeat lookup of that PC gets the zero-bubble answer. A flush input empties both tables in one cycle. Only indirect branches are expected on these ports. Direct PC-relative branches compute their own targets and never touch this block.

Top module: `ind_target_cache`

## Requirements
- R1: After reset, and after a flush, both tables are empty and every lookup misses (`hit0` low in the lookup cycle, `hit1` low in the following cycle).
- R2: Level-0 holds 16 fully associative entries and compares the full PC. On a match, `hit0` is high and `tgt0` carries the stored target combinationally in the lookup cycle.
- R3: Level-1 holds 64 sets of 4 ways. The set index is PC bits [7:2] and the tag is PC bits [17:8]. When level-0 misses and level-1 matches, `hit0` stays low and `hit1`/`tgt1` report the level-1 target in the cycle after the lookup; otherwise `hit1` is low in that cycle.
- R4: A lookup that misses level-0 and hits level-1 copies the PC and target into level-0 at the end of the lookup cycle, unless an update is presented in that cycle. A following lookup of the same PC then hits level-0.
- R5: Level-0 allocates into its lowest-numbered invalid entry, and otherwise evicts the least recently used entry. Recency is refreshed by an update or promotion written to the entry, and by a level-0 lookup hit in a cycle with no update.
- R6: An update writes its target into both levels. If the PC is already present in a level, that entry is overwritten in place and no second copy is made.
- R7: Level-1 allocates into the lowest-numbered invalid way of the set. When the set is full, it evicts the way named by a per-set round-robin pointer, which starts at way 0 after reset and advances by one on each such eviction.
- R8: When a lookup and an update name the same PC in the same cycle, the lookup misses in both levels, and the update takes effect.
- R9: A flush clears every valid bit in one cycle. A lookup in the flush cycle misses, with no `hit1` after it, and an update in the flush cycle is discarded.
- R10: Level-1 compares only the partial tag, so PCs that differ only above bit 17 share a level-1 entry and return its target. Level-0 still keeps them apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate both tables this cycle |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | 32 | PC of the lookup |
| hit0 | output | 1 | Level-0 hit, same cycle as the lookup |
| tgt0 | output | 32 | Level-0 predicted target |
| hit1 | output | 1 | Level-1 hit for the previous cycle's lookup |
| tgt1 | output | 32 | Level-1 predicted target |
| upd_valid | input | 1 | Resolved indirect branch to train |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_target | input | 32 | Correct target |

## Verification
The bench goes after the points where the two tables interact. It checks that a level-0 eviction still leaves a level-1 hit one cycle later, and that the promotion then turns the next lookup into a level-0 hit. A design that dropped or delayed the promotion would keep reporting `hit1` for a hot branch. A design with wrong recency bookkeeping would evict a recently used PC and miss where a hit is due. Same-PC lookup/update collisions, flushes that coincide with updates, full level-1 sets that wrap the round-robin pointer, and aliasing PCs that share a partial tag are all driven in a long mixed sweep over a small PC pool. A design that let a colliding lookup hit, let a flushed update survive, or evicted the wrong way would return a stale target or a hit where a miss is due.

// File: rtl/ind_target_cache.sv
module ind_target_cache #(
  parameter int PC_W    = 32,
  parameter int TGT_W   = 32,
  parameter int L0_N    = 16,
  parameter int L1_SETS = 64,
  parameter int L1_WAYS = 4,
  parameter int TAG_W   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             lk_valid,
  input  logic [PC_W-1:0]  lk_pc,
  output logic             hit0,
  output logic [TGT_W-1:0] tgt0,
  output logic             hit1,
  output logic [TGT_W-1:0] tgt1,
  input  logic             upd_valid,
  input  logic [PC_W-1:0]  upd_pc,
  input  logic [TGT_W-1:0] upd_target
);
  localparam int L0_AW = $clog2(L0_N);
  localparam int SET_W = $clog2(L1_SETS);
  localparam int WAY_W = $clog2(L1_WAYS);
  localparam int TAG_LO = SET_W + 2;

  logic [L0_N-1:0]  l0_v;
  logic [PC_W-1:0]  l0_pc  [L0_N];
  logic [TGT_W-1:0] l0_tgt [L0_N];
  logic [L0_AW-1:0] l0_age [L0_N];

  logic [L1_WAYS-1:0] l1_v   [L1_SETS];
  logic [TAG_W-1:0]   l1_tag [L1_SETS][L1_WAYS];
  logic [TGT_W-1:0]   l1_tgt [L1_SETS][L1_WAYS];
  logic [WAY_W-1:0]   l1_rr  [L1_SETS];

  wire lk_act = lk_valid && !flush && !(upd_valid && upd_pc == lk_pc);
  wire up_act = upd_valid && !flush;

  logic [L0_N-1:0]  lk_m0, up_m0;
  logic [L0_AW-1:0] lk_i0, up_i0, vic0;

  always_comb begin
    lk_i0 = '0;
    up_i0 = '0;
    vic0  = '0;
    for (int i = 0; i < L0_N; i++) begin
      lk_m0[i] = l0_v[i] && (l0_pc[i] == lk_pc);
      up_m0[i] = l0_v[i] && (l0_pc[i] == upd_pc);
      if (lk_m0[i]) lk_i0 = L0_AW'(i);
      if (up_m0[i]) up_i0 = L0_AW'(i);
      if (l0_age[i] == L0_AW'(L0_N - 1)) vic0 = L0_AW'(i);
    end
    for (int i = L0_N - 1; i >= 0; i--)
      if (!l0_v[i]) vic0 = L0_AW'(i);
  end

  assign hit0 = lk_act && |lk_m0;
  assign tgt0 = l0_tgt[lk_i0];

  wire [SET_W-1:0] lk_set = lk_pc[TAG_LO-1:2];
  wire [TAG_W-1:0] lk_tag = lk_pc[TAG_LO+TAG_W-1:TAG_LO];
  wire [SET_W-1:0] up_set = upd_pc[TAG_LO-1:2];
  wire [TAG_W-1:0] up_tag = upd_pc[TAG_LO+TAG_W-1:TAG_LO];

  logic [L1_WAYS-1:0] lk_m1, up_m1;
  logic [WAY_W-1:0]   up_w1;
  logic [TGT_W-1:0]   l1_rd;

  always_comb begin
    l1_rd = '0;
    up_w1 = l1_rr[up_set];
    for (int w = 0; w < L1_WAYS; w++) begin
      lk_m1[w] = l1_v[lk_set][w] && (l1_tag[lk_set][w] == lk_tag);
      up_m1[w] = l1_v[up_set][w] && (l1_tag[up_set][w] == up_tag);
      if (lk_m1[w]) l1_rd = l1_tgt[lk_set][w];
    end
    for (int w = L1_WAYS - 1; w >= 0; w--)
      if (!l1_v[up_set][w]) up_w1 = WAY_W'(w);
    for (int w = 0; w < L1_WAYS; w++)
      if (up_m1[w]) up_w1 = WAY_W'(w);
  end

  wire l1_hit = lk_act && !(|lk_m0) && |lk_m1;
  wire l1_evict = up_act && !(|up_m1) && (&l1_v[up_set]);

  logic             w0_en, touch_en;
  logic [L0_AW-1:0] w0_idx, touch_idx;
  logic [PC_W-1:0]  w0_pc;
  logic [TGT_W-1:0] w0_tgt;

  always_comb begin
    w0_en     = 1'b0;
    touch_en  = 1'b0;
    w0_idx    = vic0;
    w0_pc     = upd_pc;
    w0_tgt    = upd_target;
    touch_idx = lk_i0;
    if (up_act) begin
      w0_en     = 1'b1;
      w0_idx    = (|up_m0) ? up_i0 : vic0;
      touch_en  = 1'b1;
      touch_idx = w0_idx;
    end else if (hit0) begin
      touch_en  = 1'b1;
    end else if (l1_hit) begin
      w0_en     = 1'b1;
      w0_pc     = lk_pc;
      w0_tgt    = l1_rd;
      touch_en  = 1'b1;
      touch_idx = vic0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l0_v <= '0;
      for (int i = 0; i < L0_N; i++) begin
        l0_pc[i]  <= '0;
        l0_tgt[i] <= '0;
        l0_age[i] <= L0_AW'(i);
      end
    end else if (flush) begin
      l0_v <= '0;
    end else begin
      if (w0_en) begin
        l0_v[w0_idx]   <= 1'b1;
        l0_pc[w0_idx]  <= w0_pc;
        l0_tgt[w0_idx] <= w0_tgt;
      end
      if (touch_en)
        for (int i = 0; i < L0_N; i++)
          if (L0_AW'(i) == touch_idx) l0_age[i] <= '0;
          else if (l0_age[i] < l0_age[touch_idx]) l0_age[i] <= l0_age[i] + L0_AW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < L1_SETS; s++) begin
        l1_v[s]  <= '0;
        l1_rr[s] <= '0;
        for (int w = 0; w < L1_WAYS; w++) begin
          l1_tag[s][w] <= '0;
          l1_tgt[s][w] <= '0;
        end
      end
    end else if (flush) begin
      for (int s = 0; s < L1_SETS; s++) l1_v[s] <= '0;
    end else if (up_act) begin
      l1_v[up_set][up_w1]   <= 1'b1;
      l1_tag[up_set][up_w1] <= up_tag;
      l1_tgt[up_set][up_w1] <= upd_target;
      if (l1_evict) l1_rr[up_set] <= l1_rr[up_set] + WAY_W'(1);
    end
  end

  logic            r_upd;
  logic [PC_W-1:0] r_lk_pc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit1    <= 1'b0;
      tgt1    <= '0;
      r_upd   <= 1'b0;
      r_lk_pc <= '0;
    end else begin
      hit1    <= l1_hit;
      tgt1    <= l1_rd;
      r_upd   <= upd_valid;
      r_lk_pc <= lk_pc;
    end
  end

  a_r2_l0_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_m0));
  a_r3_l1_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_m1));
  a_r3_l1_follows_l0_miss: assert property (@(posedge clk) disable iff (!rst_n)
    hit1 |-> ($past(lk_valid) && !$past(hit0)));
  a_r4_promoted_hits_l0: assert property (@(posedge clk) disable iff (!rst_n)
    (hit1 && !r_upd && lk_valid && lk_pc == r_lk_pc && !upd_valid && !flush) |-> hit0);
  a_r8_collision_misses: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && upd_valid && lk_pc == upd_pc) |=> !hit1);
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!hit1 && l0_v == '0));
endmodule

// File: tb/tb_ind_target_cache.sv
`timescale 1ns/1ps
module tb_ind_target_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        hit0, hit1;
  logic [31:0] tgt0, tgt1;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic [31:0] upd_target = '0;

  always #2.5 clk = ~clk;

  ind_target_cache dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_valid(lk_valid), .lk_pc(lk_pc),
    .hit0(hit0), .tgt0(tgt0), .hit1(hit1), .tgt1(tgt1),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_target(upd_target)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  bit          m0v [16];
  logic [31:0] m0pc [16];
  logic [31:0] m0t [16];
  int          m0age [16];
  bit          m1v [64][4];
  logic [9:0]  m1tag [64][4];
  logic [31:0] m1t [64][4];
  int          m1rr [64];
  bit          e1 = 1'b0;
  logic [31:0] e1t = '0;

  task automatic chk(input bit ok, input string tg, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tg, act, exp);
    end
  endtask

  function automatic int find0(input logic [31:0] pc);
    for (int i = 0; i < 16; i++) if (m0v[i] && m0pc[i] == pc) return i;
    return -1;
  endfunction

  function automatic int find1(input logic [31:0] pc);
    for (int w = 0; w < 4; w++) if (m1v[pc[7:2]][w] && m1tag[pc[7:2]][w] == pc[17:8]) return w;
    return -1;
  endfunction

  function automatic int vict0();
    for (int i = 0; i < 16; i++) if (!m0v[i]) return i;
    for (int i = 0; i < 16; i++) if (m0age[i] == 15) return i;
    return 0;
  endfunction

  function automatic void touch0(input int e);
    int a = m0age[e];
    for (int i = 0; i < 16; i++) if (m0age[i] < a) m0age[i]++;
    m0age[e] = 0;
  endfunction

  function automatic void wr0(input int j, input logic [31:0] pc, input logic [31:0] t);
    m0v[j] = 1'b1; m0pc[j] = pc; m0t[j] = t; touch0(j);
  endfunction

  function automatic void clear_model(input bit full);
    for (int i = 0; i < 16; i++) begin
      m0v[i] = 1'b0;
      if (full) m0age[i] = i;
    end
    for (int s = 0; s < 64; s++) begin
      if (full) m1rr[s] = 0;
      for (int w = 0; w < 4; w++) m1v[s][w] = 1'b0;
    end
  endfunction

  task automatic cyc(input bit lk, input logic [31:0] lpc, input bit up, input logic [31:0] upc,
                     input logic [31:0] utg, input bit fl, input string tg);
    bit conf, h0, h1;
    int i0, w1, j, s, w;
    @(negedge clk);
    lk_valid = lk; lk_pc = lpc; upd_valid = up; upd_pc = upc; upd_target = utg; flush = fl;
    #1;
    chk(hit1 === e1, {tg, " hit1"}, 32'(hit1), 32'(e1));
    if (e1) chk(tgt1 === e1t, {tg, " tgt1"}, tgt1, e1t);
    conf = lk && up && lpc == upc;
    i0 = find0(lpc);
    h0 = !fl && lk && !conf && i0 >= 0;
    chk(hit0 === h0, {tg, " hit0"}, 32'(hit0), 32'(h0));
    if (h0) chk(tgt0 === m0t[i0], {tg, " tgt0"}, tgt0, m0t[i0]);
    if (fl) begin
      clear_model(1'b0);
      e1 = 1'b0;
    end else begin
      w1 = find1(lpc);
      h1 = lk && !conf && i0 < 0 && w1 >= 0;
      e1 = h1;
      if (h1) e1t = m1t[lpc[7:2]][w1];
      if (up) begin
        j = find0(upc);
        if (j < 0) j = vict0();
        wr0(j, upc, utg);
        s = upc[7:2];
        w = find1(upc);
        if (w < 0) begin
          for (int k = 3; k >= 0; k--) if (!m1v[s][k]) w = k;
          if (w < 0) begin
            w = m1rr[s];
            m1rr[s] = (m1rr[s] + 1) % 4;
          end
        end
        m1v[s][w] = 1'b1; m1tag[s][w] = upc[17:8]; m1t[s][w] = utg;
      end else if (h0) begin
        touch0(i0);
      end else if (h1) begin
        wr0(vict0(), lpc, e1t);
      end
    end
  endtask

  function automatic logic [31:0] pcs(input int set, input int tag, input int hi);
    return (32'(hi) << 18) | (32'(tag) << 8) | (32'(set) << 2);
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=%h exp=%h", 32'(0), 32'(1));
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    clear_model(1'b1);
    repeat (3) @(negedge clk);
    #1;
    chk(hit1 === 1'b0, "R1 reset hit1", 32'(hit1), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) cyc(1, pcs(i, 1, 0), 0, 0, 0, 0, "R1");

    for (int i = 0; i < 16; i++) cyc(0, 0, 1, pcs(i, 2, 0), 32'hA000_0000 + i, 0, "R6");
    for (int i = 0; i < 16; i++) cyc(1, pcs(i, 2, 0), 0, 0, 0, 0, "R2");
    for (int i = 0; i < 8; i++) cyc(1, pcs(i, 2, 0), 0, 0, 0, 0, "R5");
    for (int i = 16; i < 20; i++) cyc(0, 0, 1, pcs(i, 2, 0), 32'hA000_0000 + i, 0, "R5");
    for (int i = 0; i < 20; i++) cyc(1, pcs(i, 2, 0), 0, 0, 0, 0, "R3");
    for (int i = 8; i < 12; i++) begin
      cyc(1, pcs(i, 2, 0), 0, 0, 0, 0, "R4");
      cyc(1, pcs(i, 2, 0), 0, 0, 0, 0, "R4");
    end
    cyc(0, 0, 1, pcs(3, 2, 0), 32'hBEEF_0003, 0, "R6");
    cyc(1, pcs(3, 2, 0), 0, 0, 0, 0, "R6");
    cyc(1, pcs(5, 2, 0), 1, pcs(5, 2, 0), 32'hC0DE_0005, 0, "R8");
    cyc(1, pcs(5, 2, 0), 0, 0, 0, 0, "R8");

    for (int t = 1; t <= 6; t++) cyc(0, 0, 1, pcs(40, t, 0), 32'hD000_0000 + t, 0, "R7");
    for (int i = 0; i < 16; i++) cyc(0, 0, 1, pcs(i + 20, 3, 0), 32'hE000_0000 + i, 0, "R7");
    for (int t = 1; t <= 6; t++) cyc(1, pcs(40, t, 0), 0, 0, 0, 0, "R7");
    for (int t = 1; t <= 6; t++) cyc(1, pcs(40, t, 1), 0, 0, 0, 0, "R10");
    for (int t = 1; t <= 6; t++) cyc(1, pcs(40, t, 2), 0, 0, 0, 0, "R10");

    cyc(1, pcs(40, 6, 0), 1, pcs(50, 1, 0), 32'h1234_5678, 1, "R9");
    cyc(1, pcs(50, 1, 0), 0, 0, 0, 0, "R9");
    for (int i = 0; i < 20; i++) cyc(1, pcs(i, 2, 0), 0, 0, 0, 0, "R1");

    for (int n = 0; n < 6000; n++) begin
      logic [31:0] a, b;
      int r = int'($urandom % 256);
      a = pcs(int'($urandom % 4), int'($urandom % 8), int'($urandom % 2));
      b = ((r % 8) == 0) ? a : pcs(int'($urandom % 4), int'($urandom % 8), int'($urandom % 2));
      cyc(r[0] | r[1], a, r[2] & r[3], b, $urandom, r == 255, "R5");
    end
    cyc(0, 0, 0, 0, 0, 0, "R3");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule